// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects thirty-two external interrupt requests and steers each of them onto one line of a four-by-four grid of interrupt outputs. Each grid line stands for one (parent output, processor core) pair. Every source has its own trigger setup: it can be active-high level, active-low level, rising edge or falling edge. Every source also has an enable bit and a routing byte. The routing byte picks the parent output in its upper nibble and the target core in its lower nibble, each one-hot.

Software drives the controller through a simple single-cycle 32-bit write port with byte enables. It reads through a combinational read port that uses the same word address. Enables are set and cleared through two separate write-one registers, so no read-modify-write of a shared mask is needed. The enable state can be read back from a third register. A pending status register shows every source that is both asserted and enabled. Writing ones to the pending status register discards latched edges.

Inputs pass through a two-flop synchronizer before any edge or level decision is made. The grid outputs are registered.

Top module: `lirq_router`

## Requirements
- R1: After reset, the enable status, polarity, edge-select, pending-status and routing registers all read zero, and every `irq_grid` line is low.
- R2: Word addresses 0 to 7 (byte offsets 0x00 to 0x1F) hold one routing byte per source. Source n lives in word n/4, in byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)). Each byte is written only when its `bus_be` bit is set, and every byte reads back as written.
- R3: Writing word 10 (offset 0x28) sets the enable of every source whose data bit is 1. Writing word 11 (offset 0x2C) clears the enable of every source whose data bit is 1. Zero data bits leave enables unchanged. Word 9 (offset 0x24) returns the enable vector.
- R4: Word 12 (offset 0x30, polarity) and word 13 (offset 0x34, edge select) are read/write. Each byte lane is written only when its `bus_be` bit is set.
- R5: A source with edge bit 0 is level-triggered. Its bit in the pending status register (word 16, offset 0x40) is 1 exactly while it is enabled and its synchronized input equals its polarity bit (1 = active-high, 0 = active-low).
- R6: A source with edge bit 1 latches pending on the selected edge of its synchronized input: rising when polarity is 1, falling when polarity is 0. The latch holds after the input returns. The opposite edge latches nothing.
- R7: A latched edge is cleared by writing 1 to its bit of word 16, or by disabling the source. A disabled and then re-enabled source shows no pending state until a new edge arrives.
- R8: `irq_grid[p*4+c]` is high, one clock after the pending status, when at least one pending source has routing bit 4+p and routing bit c both set. It is low when no such source exists.
- R9: Reads of unmapped word addresses, and of the write-only words 10 and 11, return zero. Writes to unmapped word addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_waddr | input | 6 | Word address (byte offset divided by four), used for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Combinational read data for `bus_waddr` |
| irq_src | input | 32 | Asynchronous interrupt requests, one per source |
| irq_grid | output | 16 | Interrupt lines, bit p*4+c for parent p and core c |

## Verification
On every cycle, the assertions check the following:
- A set write leaves the written enables at one, and a clear write leaves them at zero.
- No edge latch survives a cycle in which its source was disabled.
- The grid falls silent one cycle after the pending status is empty.
- Writes to unmapped addresses leave every register untouched.

Only the bench scenarios can show the behaviours that need a chosen stimulus history:
- the level and edge polarity decisions,
- that a latch holds after its input returns,
- the write-one-to-clear path,
- the byte-lane placement of routing bytes,
- the exact grid bit chosen for a given route.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

   // word-address width of the register port
   localparam int WADDR_W = 6;

   // lowest routing-byte bit used for parent selection
   localparam int PAR_LSB = 4;

   // word indices (byte offset / 4)
   localparam logic [WADDR_W-1:0] IDX_ENSTAT = 6'd9;   // 0x24
   localparam logic [WADDR_W-1:0] IDX_ENSET  = 6'd10;  // 0x28
   localparam logic [WADDR_W-1:0] IDX_ENCLR  = 6'd11;  // 0x2C
   localparam logic [WADDR_W-1:0] IDX_POL    = 6'd12;  // 0x30
   localparam logic [WADDR_W-1:0] IDX_EDGE   = 6'd13;  // 0x34
   localparam logic [WADDR_W-1:0] IDX_STAT   = 6'd16;  // 0x40

   typedef logic [7:0] route_byte_t;

endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [WADDR_W-1:0]          waddr,
   input  logic [31:0]                 wdata,
   input  logic [3:0]                  wbe,
   output logic [31:0]                 rdata,
   input  logic [NUM_SRC-1:0]          status_i,
   output logic [NUM_SRC-1:0]          en_o,
   output logic [NUM_SRC-1:0]          pol_o,
   output logic [NUM_SRC-1:0]          edge_o,
   output logic [NUM_SRC-1:0]          clr_o,
   output route_byte_t [NUM_SRC-1:0]   route_o
);

   localparam int ROUTE_WORDS = NUM_SRC / 4;

   if (NUM_SRC > 32 || NUM_SRC % 4 != 0 || NUM_SRC < 4) begin : g_bad_src
      $error("lirq_regs: NUM_SRC must be a multiple of 4 between 4 and 32");
   end

   logic [31:0]               wmask;
   logic [NUM_SRC-1:0]        wbits;
   logic                      hit_set, hit_clr, hit_pol, hit_edge, hit_stat;
   logic                      hit_route, wr_mapped;
   logic [NUM_SRC-1:0]        en_q, pol_q, edge_q;
   route_byte_t [NUM_SRC-1:0] route_q;

   always_comb begin
      for (int k = 0; k < 4; k++) begin
         wmask[8*k +: 8] = {8{wbe[k]}};
      end
   end

   assign wbits     = wdata[NUM_SRC-1:0] & wmask[NUM_SRC-1:0];
   assign hit_route = (waddr < WADDR_W'(ROUTE_WORDS));
   assign hit_set   = wr_en && (waddr == IDX_ENSET);
   assign hit_clr   = wr_en && (waddr == IDX_ENCLR);
   assign hit_pol   = wr_en && (waddr == IDX_POL);
   assign hit_edge  = wr_en && (waddr == IDX_EDGE);
   assign hit_stat  = wr_en && (waddr == IDX_STAT);
   assign wr_mapped = hit_route || (waddr == IDX_ENSET) || (waddr == IDX_ENCLR) ||
                      (waddr == IDX_POL) || (waddr == IDX_EDGE) ||
                      (waddr == IDX_STAT) || (waddr == IDX_ENSTAT);

   // enable register: separate set and clear write ports
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (hit_set) begin
         en_q <= en_q | wbits;
      end else if (hit_clr) begin
         en_q <= en_q & ~wbits;
      end
   end

   // polarity and edge-select: plain byte-masked read/write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         edge_q <= '0;
      end else begin
         if (hit_pol)  pol_q  <= (pol_q  & ~wmask[NUM_SRC-1:0]) | wbits;
         if (hit_edge) edge_q <= (edge_q & ~wmask[NUM_SRC-1:0]) | wbits;
      end
   end

   // routing bytes, four per word, lane = source index modulo 4
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
      end else if (wr_en) begin
         for (int s = 0; s < NUM_SRC; s++) begin
            if (waddr == WADDR_W'(s / 4) && wbe[s % 4]) begin
               route_q[s] <= wdata[8*(s % 4) +: 8];
            end
         end
      end
   end

   // write-one-to-clear pulse for latched edges
   assign clr_o = hit_stat ? wbits : '0;

   always_comb begin
      rdata = '0;
      if (hit_route) begin
         for (int s = 0; s < NUM_SRC; s++) begin
            if (waddr == WADDR_W'(s / 4)) rdata[8*(s % 4) +: 8] = route_q[s];
         end
      end else begin
         case (waddr)
            IDX_ENSTAT: rdata[NUM_SRC-1:0] = en_q;
            IDX_POL:    rdata[NUM_SRC-1:0] = pol_q;
            IDX_EDGE:   rdata[NUM_SRC-1:0] = edge_q;
            IDX_STAT:   rdata[NUM_SRC-1:0] = status_i;
            default:    rdata = '0;
         endcase
      end
   end

   assign en_o    = en_q;
   assign pol_o   = pol_q;
   assign edge_o  = edge_q;
   assign route_o = route_q;

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set |=> ((en_q & $past(wbits)) == $past(wbits)));

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |=> ((en_q & $past(wbits)) == '0));

   // R9
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_mapped) |=> ($stable(en_q) && $stable(pol_q) &&
                                 $stable(edge_q) && $stable(route_q)));

endmodule

// File: rtl/lirq_trigger.sv
module lirq_trigger #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] sync_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] pol_i,
   input  logic [NUM_SRC-1:0] edge_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] status_o
);

   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] latch_q;
   logic [NUM_SRC-1:0] hit;
   logic [NUM_SRC-1:0] level_act;

   // selected edge: rising when polarity is 1, falling when 0
   assign hit = (pol_i & sync_i & ~prev_q) | (~pol_i & ~sync_i & prev_q);

   // active when the input matches the polarity bit
   assign level_act = ~(sync_i ^ pol_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         latch_q <= '0;
      end else begin
         prev_q  <= sync_i;
         // a new edge wins over a same-cycle clear; disable always wins
         latch_q <= ((latch_q & ~clr_i) | hit) & en_i & edge_i;
      end
   end

   assign status_o = en_i & ((edge_i & latch_q) | (~edge_i & level_act));

   // R7
   latch_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((latch_q & ~$past(en_i)) == '0));

   // R5
   status_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_i[0]) |-> !status_o[0]);

endmodule

// File: rtl/lirq_fanout.sv
module lirq_fanout
   import lirq_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_PAR  = 4,
   parameter int NUM_CORE = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          status_i,
   input  route_byte_t [NUM_SRC-1:0]   route_i,
   output logic [NUM_PAR*NUM_CORE-1:0] grid_o
);

   localparam int NUM_OUT = NUM_PAR * NUM_CORE;

   if (NUM_PAR > 8 - PAR_LSB || NUM_CORE > PAR_LSB) begin : g_bad_grid
      $error("lirq_fanout: parent and core selects must fit their nibbles");
   end

   logic [NUM_OUT-1:0] grid_d;
   logic [NUM_OUT-1:0] grid_q;

   always_comb begin
      grid_d = '0;
      for (int p = 0; p < NUM_PAR; p++) begin
         for (int c = 0; c < NUM_CORE; c++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
               grid_d[p*NUM_CORE + c] = grid_d[p*NUM_CORE + c] |
                  (status_i[s] & route_i[s][PAR_LSB + p] & route_i[s][c]);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grid_q <= '0;
      else        grid_q <= grid_d;
   end

   assign grid_o = grid_q;

   // R8
   grid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_i == '0) |=> (grid_o == '0));

   // R8
   grid_unrouted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_i == '0) |=> (grid_o == '0));

endmodule

// File: rtl/lirq_router.sv
module lirq_router
   import lirq_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int NUM_PAR     = 4,
   parameter int NUM_CORE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [WADDR_W-1:0]          bus_waddr,
   input  logic [31:0]                 bus_wdata,
   input  logic [3:0]                  bus_be,
   output logic [31:0]                 bus_rdata,
   input  logic [NUM_SRC-1:0]          irq_src,
   output logic [NUM_PAR*NUM_CORE-1:0] irq_grid
);

   logic [NUM_SRC-1:0]        src_sync;
   logic [NUM_SRC-1:0]        en, pol, edge_sel, stat_clr, status;
   route_byte_t [NUM_SRC-1:0] route;

   lirq_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (irq_src),
      .sync_o  (src_sync)
   );

   lirq_regs #(
      .NUM_SRC (NUM_SRC)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .waddr    (bus_waddr),
      .wdata    (bus_wdata),
      .wbe      (bus_be),
      .rdata    (bus_rdata),
      .status_i (status),
      .en_o     (en),
      .pol_o    (pol),
      .edge_o   (edge_sel),
      .clr_o    (stat_clr),
      .route_o  (route)
   );

   lirq_trigger #(
      .NUM_SRC (NUM_SRC)
   ) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (src_sync),
      .en_i     (en),
      .pol_i    (pol),
      .edge_i   (edge_sel),
      .clr_i    (stat_clr),
      .status_o (status)
   );

   lirq_fanout #(
      .NUM_SRC  (NUM_SRC),
      .NUM_PAR  (NUM_PAR),
      .NUM_CORE (NUM_CORE)
   ) u_fan (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status),
      .route_i  (route),
      .grid_o   (irq_grid)
   );

endmodule

// File: tb/lirq_router_tb.sv
module lirq_router_tb;
   import lirq_pkg::*;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_wr = 1'b0;
   logic [WADDR_W-1:0] bus_waddr = '0;
   logic [31:0]        bus_wdata = '0;
   logic [3:0]         bus_be = '0;
   logic [31:0]        bus_rdata;
   logic [31:0]        irq_src = '0;
   logic [15:0]        irq_grid;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   lirq_router u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_waddr (bus_waddr),
      .bus_wdata (bus_wdata),
      .bus_be    (bus_be),
      .bus_rdata (bus_rdata),
      .irq_src   (irq_src),
      .irq_grid  (irq_grid)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_waddr = a;
      bus_wdata = d;
      bus_be    = be;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_be    = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_waddr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(IDX_ENSTAT, d); check("R1 enable", d, 0);
      rd(IDX_POL, d);    check("R1 polarity", d, 0);
      rd(IDX_EDGE, d);   check("R1 edge", d, 0);
      rd(IDX_STAT, d);   check("R1 status", d, 0);
      rd(6'd0, d);       check("R1 route", d, 0);
      check("R1 grid", {16'h0, irq_grid}, 0);
   endtask

   task automatic t_route();
      logic [31:0] d;
      wr(6'd0, 32'h8421_1248, 4'hF);
      rd(6'd0, d); check("R2 full word", d, 32'h8421_1248);
      wr(6'd1, 32'hAABB_CCDD, 4'b0010);
      rd(6'd1, d); check("R2 lane 1 only", d, 32'h0000_CC00);
      wr(6'd0, 32'h0, 4'hF);
      wr(6'd1, 32'h0, 4'hF);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr(IDX_ENSET, 32'h0000_00F0, 4'hF);
      wr(IDX_ENSET, 32'h0000_0003, 4'hF);
      rd(IDX_ENSTAT, d); check("R3 set accumulates", d, 32'h0000_00F3);
      wr(IDX_ENCLR, 32'h0000_0030, 4'hF);
      rd(IDX_ENSTAT, d); check("R3 clear selective", d, 32'h0000_00C3);
      wr(IDX_ENCLR, 32'hFFFF_FFFF, 4'hF);
      rd(IDX_ENSTAT, d); check("R3 clear all", d, 0);
   endtask

   task automatic t_polarity_edge();
      logic [31:0] d;
      wr(IDX_POL, 32'h1234_5678, 4'hF);
      rd(IDX_POL, d); check("R4 polarity rw", d, 32'h1234_5678);
      wr(IDX_POL, 32'hFFFF_FFFF, 4'b0100);
      rd(IDX_POL, d); check("R4 polarity lane", d, 32'h12FF_5678);
      wr(IDX_EDGE, 32'hFFFF_FFFF, 4'b0001);
      rd(IDX_EDGE, d); check("R4 edge lane", d, 32'h0000_00FF);
      wr(IDX_POL, 32'h0, 4'hF);
      wr(IDX_EDGE, 32'h0, 4'hF);
   endtask

   task automatic t_level();
      logic [31:0] d;
      // source 5 -> parent 2 (bit 6), core 1 (bit 1): word 1, lane 1
      wr(6'd1, 32'h0000_4200, 4'b0010);
      wr(IDX_POL, 32'h0000_0020, 4'hF);
      wr(IDX_ENSET, 32'h0000_0020, 4'hF);
      settle();
      rd(IDX_STAT, d); check("R5 high level idle", d, 0);
      irq_src[5] = 1'b1;
      settle();
      rd(IDX_STAT, d); check("R5 high level active", d, 32'h0000_0020);
      check("R8 grid bit 9", {16'h0, irq_grid}, 32'h0000_0200);
      irq_src[5] = 1'b0;
      settle();
      rd(IDX_STAT, d); check("R5 level follows input", d, 0);
      check("R8 grid released", {16'h0, irq_grid}, 0);
      wr(IDX_POL, 32'h0, 4'hF);
      settle();
      rd(IDX_STAT, d); check("R5 low level active", d, 32'h0000_0020);
      wr(IDX_ENCLR, 32'h0000_0020, 4'hF);
      settle();
      rd(IDX_STAT, d); check("R5 disabled hides", d, 0);
      wr(6'd1, 32'h0, 4'hF);
   endtask

   task automatic t_edge();
      logic [31:0] d;
      // source 10 -> parent 0 (bit 4), core 3 (bit 3): word 2, lane 2
      wr(6'd2, 32'h0018_0000, 4'b0100);
      wr(IDX_EDGE, 32'h0000_0400, 4'hF);
      wr(IDX_POL, 32'h0000_0400, 4'hF);
      wr(IDX_ENSET, 32'h0000_0400, 4'hF);
      settle();
      rd(IDX_STAT, d); check("R6 no edge yet", d, 0);
      irq_src[10] = 1'b1;
      settle();
      irq_src[10] = 1'b0;
      settle();
      rd(IDX_STAT, d); check("R6 rising latched", d, 32'h0000_0400);
      check("R8 grid bit 3", {16'h0, irq_grid}, 32'h0000_0008);
      wr(IDX_STAT, 32'h0000_0400, 4'hF);
      settle();
      rd(IDX_STAT, d); check("R7 write-one clear", d, 0);
      check("R7 grid after clear", {16'h0, irq_grid}, 0);
      wr(IDX_POL, 32'h0, 4'hF);
      irq_src[10] = 1'b1;
      settle();
      rd(IDX_STAT, d); check("R6 rising ignored when falling", d, 0);
      irq_src[10] = 1'b0;
      settle();
      rd(IDX_STAT, d); check("R6 falling latched", d, 32'h0000_0400);
      wr(IDX_ENCLR, 32'h0000_0400, 4'hF);
      wr(IDX_ENSET, 32'h0000_0400, 4'hF);
      settle();
      rd(IDX_STAT, d); check("R7 disable drops latch", d, 0);
      wr(IDX_ENCLR, 32'hFFFF_FFFF, 4'hF);
      wr(IDX_EDGE, 32'h0, 4'hF);
      wr(6'd2, 32'h0, 4'hF);
   endtask

   task automatic t_grid();
      // source 0 -> parent 0 core 0 ; source 31 -> parent 3 core 3
      wr(6'd0, 32'h0000_0011, 4'b0001);
      wr(6'd7, 32'h8800_0000, 4'b1000);
      wr(IDX_POL, 32'h8000_0001, 4'hF);
      wr(IDX_ENSET, 32'h8000_0001, 4'hF);
      irq_src[0]  = 1'b1;
      irq_src[31] = 1'b1;
      settle();
      check("R8 grid corners", {16'h0, irq_grid}, 32'h0000_8001);
      irq_src[0] = 1'b0;
      settle();
      check("R8 grid one corner", {16'h0, irq_grid}, 32'h0000_8000);
      irq_src[31] = 1'b0;
      wr(IDX_ENCLR, 32'hFFFF_FFFF, 4'hF);
      wr(IDX_POL, 32'h0, 4'hF);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(IDX_ENSET, 32'h0000_0101, 4'hF);
      wr(6'd8,  32'hFFFF_FFFF, 4'hF);
      wr(6'd14, 32'hFFFF_FFFF, 4'hF);
      wr(6'd30, 32'hFFFF_FFFF, 4'hF);
      rd(6'd8, d);       check("R9 read 0x20", d, 0);
      rd(6'd14, d);      check("R9 read 0x38", d, 0);
      rd(IDX_ENSET, d);  check("R9 set reads zero", d, 0);
      rd(IDX_ENCLR, d);  check("R9 clear reads zero", d, 0);
      rd(IDX_ENSTAT, d); check("R9 enables untouched", d, 32'h0000_0101);
      rd(IDX_POL, d);    check("R9 polarity untouched", d, 0);
      rd(6'd3, d);       check("R9 route untouched", d, 0);
      wr(IDX_ENCLR, 32'hFFFF_FFFF, 4'hF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_route();
      t_enable();
      t_polarity_edge();
      t_level();
      t_edge();
      t_grid();
      t_unmapped();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule